// File: doc/BRIEF.md
# Local register cache spill/refill controller

This block sequences procedure entry and exit for a stack machine that keeps up to four locals of the active procedure in registers. A 3-bit live count says how many of the four hold live values. On a call the controller pushes the top-of-stack word and puts the return address in the top-of-stack register. It then writes the live locals to memory just below the frame pointer, builds the callee frame and takes a new live count from the instruction. Last, it loads the callee's locals (its arguments) from the words just below the new frame pointer.

On a return it recovers the caller's live count, the return address, the stack pointer and the frame pointer, then reloads the caller's locals from the same slots they were spilled to. The return address can come from the top-of-stack register or from the callee frame. The controller owns the frame pointer, the stack pointer, the live count, the top-of-stack register and the four local registers. It drives one memory port with combinational read data and makes at most one access per cycle. A surrounding core writes locals and the top-of-stack through simple write ports between sequences.

Top module: `lcache_ctrl`

## Requirements
- R1: After reset, frame_ptr equals FP_RST, stack_ptr equals SP_RST, and live_cnt, tos_val, ret_pc and all locals are zero. busy is low and no memory access is made.
- R2: busy rises in the cycle after an accepted call_req or ret_req and stays high until the last step. call_req has priority over ret_req. Requests seen while busy are ignored. There is never a read and a write in the same cycle, and no access at all while idle.
- R3: The first step of a call writes tos_val to stack_ptr+1, increments stack_ptr and sets tos_val to call_pc+1.
- R4: If live_cnt is nonzero at a call, frame_ptr first drops by live_cnt. Then v[live_cnt] down to v1 are written to successive addresses, with frame_ptr incremented after each write, so frame_ptr ends where it started. If live_cnt is zero, this spill is skipped.
- R5: Frame setup takes two writes. First the current frame_ptr is written at stack_ptr+op_arg. Then the old live_cnt is written one word above it. Afterwards frame_ptr equals the first address, stack_ptr equals the second, and live_cnt holds the new count.
- R6: A refill runs whenever the count just loaded is nonzero, after a call and after a return. frame_ptr drops by the count, then successive words are read into v[count] down to v1, with frame_ptr incremented after each read. A zero count skips the refill.
- R7: A count taken from call_nu or from memory that is above 4 becomes 4; a memory word is compared as a whole word. live_cnt never exceeds 4.
- R8: A return with ret_from_frame=0 runs three steps. The first reads live_cnt from memory at stack_ptr and copies tos_val[AW-1:0] to ret_pc. The second reads tos_val from frame_ptr-op_arg and sets stack_ptr to frame_ptr-op_arg-1. The third reads frame_ptr from memory at frame_ptr. A refill follows per R6.
- R9: A return with ret_from_frame=1 runs four steps. It reads ret_pc from frame_ptr+2, then live_cnt from frame_ptr+1, then sets stack_ptr to frame_ptr-op_arg, then reads frame_ptr from frame_ptr. A refill follows per R6.
- R10: A call lasts 3 + (u?u+1:0) + (n?n+1:0) busy cycles, where u is the live count at the call and n the clamped new count. A return lasts 3 cycles (R8 form) or 4 cycles (R9 form), plus (n?n+1:0) for the count it restores.
- R11: loc_we writes loc_wdata into local loc_sel+1 (loc_sel 0 selects v1, 3 selects v4). tos_we writes tos_wdata into tos_val. Both act only in an idle cycle without a request, and are ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Start a call sequence (idle only) |
| ret_req | input | 1 | Start a return sequence (idle only) |
| ret_from_frame | input | 1 | Return address held in frame rather than in top-of-stack |
| op_arg | input | AW | Frame offset on a call, argument drop on a return |
| call_pc | input | AW | Address of the call instruction |
| call_nu | input | 3 | Callee live-count field of the instruction |
| loc_we | input | 1 | Local register write strobe |
| loc_sel | input | 2 | Local register select (0 = v1) |
| loc_wdata | input | DW | Local register write data |
| tos_we | input | 1 | Top-of-stack write strobe |
| tos_wdata | input | DW | Top-of-stack write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle as mem_addr |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| busy | output | 1 | Sequence in progress |
| frame_ptr | output | AW | Frame pointer |
| stack_ptr | output | AW | Stack pointer |
| live_cnt | output | 3 | Live local count |
| tos_val | output | DW | Top-of-stack register |
| ret_pc | output | AW | Return address recovered by the last return |
| locals | output | 4*DW | v1 in bits DW-1:0 up to v4 in the top DW bits |

## Verification
The hardest case is a return that has to reload a full cache, because that needs a live count of four stored in the frame by an earlier call. A clamped count read back from memory is just as hard to reach. The directed part of the bench builds this history: it makes a call with a new count of seven and then returns. It then plants an out-of-range count and a return address in the frame before a frame-held return. Seeded random nesting of up to six calls, mixed with returns of both forms, then repeats spills and refills of every length. A reference model in the bench tracks every register and the whole memory image.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    localparam int unsigned NUM_LOCALS = 4;
    localparam int unsigned UW         = 3;
    localparam int unsigned SW         = $clog2(NUM_LOCALS);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_C_PUSH,
        ST_C_SADJ,
        ST_C_SPILL,
        ST_C_FSAVE,
        ST_C_UPUSH,
        ST_X_RADJ,
        ST_X_FILL,
        ST_R_UGET,
        ST_R_SPPOP,
        ST_F_RA,
        ST_F_UGET,
        ST_F_SPSET,
        ST_R_FPGET
    } seq_state_t;

    typedef enum logic [3:0] {
        AS_NONE,
        AS_SP_INC,
        AS_SP,
        AS_SP_OFF,
        AS_FP,
        AS_FP_ARG,
        AS_FP_ONE,
        AS_FP_TWO
    } addr_src_t;

    typedef struct packed {
        logic      we;
        logic      re;
        addr_src_t src;
    } mem_cmd_t;

    function automatic logic [UW-1:0] clamp_u(input logic [UW-1:0] x);
        return (x > UW'(NUM_LOCALS)) ? UW'(NUM_LOCALS) : x;
    endfunction

endpackage

// File: rtl/lcc_fsm.sv
module lcc_fsm
    import lcc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic          ret_from_frame,
    input  logic [UW-1:0] u_cur,
    input  logic [UW-1:0] nu_q,
    output seq_state_t    state,
    output logic [UW-1:0] cnt
);

    seq_state_t nxt;
    logic       cnt_last;

    assign cnt_last = (cnt == UW'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (call_req)
                    nxt = ST_C_PUSH;
                else if (ret_req)
                    nxt = ret_from_frame ? ST_F_RA : ST_R_UGET;
            end
            ST_C_PUSH:  nxt = (u_cur == '0) ? ST_C_FSAVE : ST_C_SADJ;
            ST_C_SADJ:  nxt = ST_C_SPILL;
            ST_C_SPILL: nxt = cnt_last ? ST_C_FSAVE : ST_C_SPILL;
            ST_C_FSAVE: nxt = ST_C_UPUSH;
            ST_C_UPUSH: nxt = (nu_q == '0) ? ST_IDLE : ST_X_RADJ;
            ST_X_RADJ:  nxt = ST_X_FILL;
            ST_X_FILL:  nxt = cnt_last ? ST_IDLE : ST_X_FILL;
            ST_R_UGET:  nxt = ST_R_SPPOP;
            ST_R_SPPOP: nxt = ST_R_FPGET;
            ST_F_RA:    nxt = ST_F_UGET;
            ST_F_UGET:  nxt = ST_F_SPSET;
            ST_F_SPSET: nxt = ST_R_FPGET;
            ST_R_FPGET: nxt = (u_cur == '0) ? ST_IDLE : ST_X_RADJ;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_C_SADJ || state == ST_X_RADJ)
                cnt <= u_cur;
            else if (state == ST_C_SPILL || state == ST_X_FILL)
                cnt <= cnt - UW'(1);
        end
    end

endmodule

// File: rtl/lcc_local_bank.sv
module lcc_local_bank
    import lcc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 port_en,
    input  logic [SW-1:0]        port_sel,
    input  logic [DW-1:0]        port_data,
    input  logic                 fill_en,
    input  logic [UW-1:0]        slot,
    input  logic [DW-1:0]        fill_data,
    output logic [DW-1:0]        spill_data,
    output logic [NUM_LOCALS*DW-1:0] flat
);

    for (genvar g = 0; g < NUM_LOCALS; g++) begin : g_loc
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= '0;
            else if (fill_en && slot == UW'(g + 1))
                r <= fill_data;
            else if (port_en && port_sel == SW'(g))
                r <= port_data;
        end
        assign flat[g*DW +: DW] = r;
    end

    always_comb begin
        spill_data = '0;
        for (int i = 0; i < NUM_LOCALS; i++) begin
            if (slot == UW'(i + 1))
                spill_data = flat[i*DW +: DW];
        end
    end

endmodule

// File: rtl/lcc_frame_regs.sv
module lcc_frame_regs
    import lcc_pkg::*;
#(
    parameter int             AW     = 8,
    parameter int             DW     = 16,
    parameter logic [AW-1:0]  FP_RST = 8'h80,
    parameter logic [AW-1:0]  SP_RST = 8'h40
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_state_t    state,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic [AW-1:0] op_arg,
    input  logic [AW-1:0] call_pc,
    input  logic [UW-1:0] call_nu,
    input  logic          tos_we,
    input  logic [DW-1:0] tos_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] fp,
    output logic [AW-1:0] sp,
    output logic [UW-1:0] u,
    output logic [UW-1:0] nu_q,
    output logic [AW-1:0] arg_q,
    output logic [DW-1:0] tos,
    output logic [AW-1:0] ret_pc
);

    localparam logic [DW-1:0] UMAX_W = DW'(NUM_LOCALS);

    logic [AW-1:0] pc_q;
    logic [UW-1:0] u_from_mem;
    logic [AW-1:0] fp_less_arg;

    assign u_from_mem  = (mem_rdata > UMAX_W) ? UW'(NUM_LOCALS) : mem_rdata[UW-1:0];
    assign fp_less_arg = fp - arg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fp     <= FP_RST;
            sp     <= SP_RST;
            u      <= '0;
            nu_q   <= '0;
            arg_q  <= '0;
            pc_q   <= '0;
            tos    <= '0;
            ret_pc <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (call_req) begin
                        arg_q <= op_arg;
                        pc_q  <= call_pc;
                        nu_q  <= clamp_u(call_nu);
                    end else if (ret_req) begin
                        arg_q <= op_arg;
                    end else if (tos_we) begin
                        tos <= tos_wdata;
                    end
                end
                ST_C_PUSH: begin
                    sp  <= sp + AW'(1);
                    tos <= DW'(pc_q) + DW'(1);
                end
                ST_C_SADJ:  fp <= fp - AW'(u);
                ST_C_SPILL: fp <= fp + AW'(1);
                ST_C_FSAVE: begin
                    sp <= sp + arg_q;
                    fp <= sp + arg_q;
                end
                ST_C_UPUSH: begin
                    sp <= sp + AW'(1);
                    u  <= nu_q;
                end
                ST_X_RADJ:  fp <= fp - AW'(u);
                ST_X_FILL:  fp <= fp + AW'(1);
                ST_R_UGET: begin
                    u      <= u_from_mem;
                    ret_pc <= tos[AW-1:0];
                end
                ST_R_SPPOP: begin
                    tos <= mem_rdata;
                    sp  <= fp_less_arg - AW'(1);
                end
                ST_F_RA:    ret_pc <= mem_rdata[AW-1:0];
                ST_F_UGET:  u      <= u_from_mem;
                ST_F_SPSET: sp     <= fp_less_arg;
                ST_R_FPGET: fp     <= mem_rdata[AW-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lcache_ctrl.sv
module lcache_ctrl
    import lcc_pkg::*;
#(
    parameter int             AW     = 8,
    parameter int             DW     = 16,
    parameter logic [AW-1:0]  FP_RST = 8'h80,
    parameter logic [AW-1:0]  SP_RST = 8'h40
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       call_req,
    input  logic                       ret_req,
    input  logic                       ret_from_frame,
    input  logic [AW-1:0]              op_arg,
    input  logic [AW-1:0]              call_pc,
    input  logic [2:0]                 call_nu,
    input  logic                       loc_we,
    input  logic [1:0]                 loc_sel,
    input  logic [DW-1:0]              loc_wdata,
    input  logic                       tos_we,
    input  logic [DW-1:0]              tos_wdata,
    input  logic [DW-1:0]              mem_rdata,
    output logic [AW-1:0]              mem_addr,
    output logic                       mem_we,
    output logic                       mem_re,
    output logic [DW-1:0]              mem_wdata,
    output logic                       busy,
    output logic [AW-1:0]              frame_ptr,
    output logic [AW-1:0]              stack_ptr,
    output logic [2:0]                 live_cnt,
    output logic [DW-1:0]              tos_val,
    output logic [AW-1:0]              ret_pc,
    output logic [4*DW-1:0]            locals
);

    seq_state_t    state;
    logic [UW-1:0] cnt;
    logic [UW-1:0] nu_q;
    logic [AW-1:0] arg_q;
    logic [DW-1:0] spill_word;
    logic          port_en;
    mem_cmd_t      cmd;

    assign busy    = (state != ST_IDLE);
    assign port_en = (state == ST_IDLE) && loc_we && !call_req && !ret_req;

    lcc_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .call_req       (call_req),
        .ret_req        (ret_req),
        .ret_from_frame (ret_from_frame),
        .u_cur          (live_cnt),
        .nu_q           (nu_q),
        .state          (state),
        .cnt            (cnt)
    );

    lcc_frame_regs #(
        .AW     (AW),
        .DW     (DW),
        .FP_RST (FP_RST),
        .SP_RST (SP_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .call_req  (call_req),
        .ret_req   (ret_req),
        .op_arg    (op_arg),
        .call_pc   (call_pc),
        .call_nu   (call_nu),
        .tos_we    (tos_we),
        .tos_wdata (tos_wdata),
        .mem_rdata (mem_rdata),
        .fp        (frame_ptr),
        .sp        (stack_ptr),
        .u         (live_cnt),
        .nu_q      (nu_q),
        .arg_q     (arg_q),
        .tos       (tos_val),
        .ret_pc    (ret_pc)
    );

    lcc_local_bank #(
        .DW (DW)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .port_en    (port_en),
        .port_sel   (loc_sel),
        .port_data  (loc_wdata),
        .fill_en    (state == ST_X_FILL),
        .slot       (cnt),
        .fill_data  (mem_rdata),
        .spill_data (spill_word),
        .flat       (locals)
    );

    // one access per step: pick direction and address source
    always_comb begin
        cmd       = '{we: 1'b0, re: 1'b0, src: AS_NONE};
        mem_wdata = '0;
        unique case (state)
            ST_C_PUSH: begin
                cmd       = '{we: 1'b1, re: 1'b0, src: AS_SP_INC};
                mem_wdata = tos_val;
            end
            ST_C_SPILL: begin
                cmd       = '{we: 1'b1, re: 1'b0, src: AS_FP};
                mem_wdata = spill_word;
            end
            ST_C_FSAVE: begin
                cmd       = '{we: 1'b1, re: 1'b0, src: AS_SP_OFF};
                mem_wdata = DW'(frame_ptr);
            end
            ST_C_UPUSH: begin
                cmd       = '{we: 1'b1, re: 1'b0, src: AS_SP_INC};
                mem_wdata = DW'(live_cnt);
            end
            ST_X_FILL:  cmd = '{we: 1'b0, re: 1'b1, src: AS_FP};
            ST_R_UGET:  cmd = '{we: 1'b0, re: 1'b1, src: AS_SP};
            ST_R_SPPOP: cmd = '{we: 1'b0, re: 1'b1, src: AS_FP_ARG};
            ST_F_RA:    cmd = '{we: 1'b0, re: 1'b1, src: AS_FP_TWO};
            ST_F_UGET:  cmd = '{we: 1'b0, re: 1'b1, src: AS_FP_ONE};
            ST_R_FPGET: cmd = '{we: 1'b0, re: 1'b1, src: AS_FP};
            default: ;
        endcase
    end

    always_comb begin
        unique case (cmd.src)
            AS_SP_INC: mem_addr = stack_ptr + AW'(1);
            AS_SP:     mem_addr = stack_ptr;
            AS_SP_OFF: mem_addr = stack_ptr + arg_q;
            AS_FP:     mem_addr = frame_ptr;
            AS_FP_ARG: mem_addr = frame_ptr - arg_q;
            AS_FP_ONE: mem_addr = frame_ptr + AW'(1);
            AS_FP_TWO: mem_addr = frame_ptr + AW'(2);
            default:   mem_addr = '0;
        endcase
    end

    assign mem_we = cmd.we;
    assign mem_re = cmd.re;

endmodule

// File: rtl/lcc_checker.sv
module lcc_checker #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          call_req,
    input logic          ret_req,
    input logic          ret_from_frame,
    input logic          busy,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [AW-1:0] stack_ptr,
    input logic [AW-1:0] frame_ptr,
    input logic [DW-1:0] tos_val,
    input logic [2:0]    live_cnt
);

    assert_single_access_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re));

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && (call_req || ret_req)) |=> busy);

    assert_count_limit_R7: assert property (@(posedge clk) disable iff (rst)
        live_cnt <= 3'd4);

    assert_call_push_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && call_req) |=>
            (mem_we && mem_addr == $past(stack_ptr) + AW'(1) && mem_wdata == $past(tos_val)));

    assert_ret_first_read_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && ret_req && !call_req && !ret_from_frame) |=>
            (mem_re && mem_addr == $past(stack_ptr)));

    assert_frame_ret_first_read_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && ret_req && !call_req && ret_from_frame) |=>
            (mem_re && mem_addr == $past(frame_ptr) + AW'(2)));

endmodule

bind lcache_ctrl lcc_checker #(.AW(AW), .DW(DW)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .call_req       (call_req),
    .ret_req        (ret_req),
    .ret_from_frame (ret_from_frame),
    .busy           (busy),
    .mem_we         (mem_we),
    .mem_re         (mem_re),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .stack_ptr      (stack_ptr),
    .frame_ptr      (frame_ptr),
    .tos_val        (tos_val),
    .live_cnt       (live_cnt)
);

// File: tb/lcache_ctrl_tb_top.sv
module lcache_ctrl_tb_top;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CLK_PERIOD = 10;
    localparam logic [AW-1:0] FP0 = 8'h80;
    localparam logic [AW-1:0] SP0 = 8'h40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic call_req = 1'b0, ret_req = 1'b0, ret_from_frame = 1'b0;
    logic [AW-1:0] op_arg = '0, call_pc = '0;
    logic [2:0] call_nu = '0;
    logic loc_we = 1'b0;
    logic [1:0] loc_sel = '0;
    logic [DW-1:0] loc_wdata = '0;
    logic tos_we = 1'b0;
    logic [DW-1:0] tos_wdata = '0;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_we, mem_re;
    logic [DW-1:0] mem_wdata;
    logic busy;
    logic [AW-1:0] frame_ptr, stack_ptr, ret_pc;
    logic [2:0] live_cnt;
    logic [DW-1:0] tos_val;
    logic [4*DW-1:0] locals;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcache_ctrl dut_i (
        .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req),
        .ret_from_frame(ret_from_frame), .op_arg(op_arg), .call_pc(call_pc),
        .call_nu(call_nu), .loc_we(loc_we), .loc_sel(loc_sel), .loc_wdata(loc_wdata),
        .tos_we(tos_we), .tos_wdata(tos_wdata), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .busy(busy), .frame_ptr(frame_ptr), .stack_ptr(stack_ptr), .live_cnt(live_cnt),
        .tos_val(tos_val), .ret_pc(ret_pc), .locals(locals)
    );

    // bench memory, combinational read
    logic [DW-1:0] mem [0:255];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    // reference model
    logic [DW-1:0] mm [0:255];
    logic [AW-1:0] m_fp, m_sp, m_rpc;
    logic [2:0]    m_u;
    logic [DW-1:0] m_tos;
    logic [DW-1:0] m_v [1:4];

    int n_chk = 0;
    int n_bad = 0;
    int depth = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] clamp3(input logic [2:0] x);
        return (x > 3'd4) ? 3'd4 : x;
    endfunction

    function automatic logic [2:0] clampw(input logic [DW-1:0] w);
        return (w > DW'(4)) ? 3'd4 : w[2:0];
    endfunction

    task automatic model_refill();
        if (m_u != 3'd0) begin
            m_fp = m_fp - AW'(m_u);
            for (int i = int'(m_u); i >= 1; i--) begin
                m_v[i] = mm[m_fp];
                m_fp = m_fp + AW'(1);
            end
        end
    endtask

    task automatic check_all(input string tag);
        int bad;
        chk(tag, "frame_ptr", 64'(frame_ptr), 64'(m_fp));
        chk(tag, "stack_ptr", 64'(stack_ptr), 64'(m_sp));
        chk(tag, "live_cnt", 64'(live_cnt), 64'(m_u));
        chk(tag, "tos_val", 64'(tos_val), 64'(m_tos));
        chk(tag, "ret_pc", 64'(ret_pc), 64'(m_rpc));
        for (int i = 1; i <= 4; i++)
            chk(tag, $sformatf("local v%0d", i), 64'(locals[(i-1)*DW +: DW]), 64'(m_v[i]));
        bad = 0;
        for (int a = 0; a < 256; a++) if (mem[a] !== mm[a]) bad++;
        chk(tag, "memory mismatches", 64'(bad), 64'd0);
    endtask

    task automatic wait_done(input bit disturb, output int cyc);
        cyc = 0;
        while (busy) begin
            if (disturb && cyc == 0) begin
                loc_we = 1'b1; loc_sel = 2'd0; loc_wdata = 16'hDEAD;
                tos_we = 1'b1; tos_wdata = 16'hBEEF;
                ret_req = 1'b1;
            end
            @(posedge clk); #1;
            loc_we = 1'b0; tos_we = 1'b0; ret_req = 1'b0;
            cyc++;
            if (cyc > 400) begin
                chk("R2", "sequence hung, busy cycles", 64'(cyc), 64'd0);
                break;
            end
        end
    endtask

    task automatic do_call(input logic [AW-1:0] pc, input logic [AW-1:0] k,
                           input logic [2:0] nu, input bit disturb, input string tag);
        int exp_cyc, cyc;
        logic [2:0] cnu;
        logic [AW-1:0] a;
        cnu = clamp3(nu);
        exp_cyc = 3 + ((m_u != 0) ? 1 + int'(m_u) : 0) + ((cnu != 0) ? 1 + int'(cnu) : 0);
        a = m_sp + AW'(1);
        mm[a] = m_tos;
        m_sp = a;
        m_tos = DW'(pc) + DW'(1);
        if (m_u != 3'd0) begin
            m_fp = m_fp - AW'(m_u);
            for (int i = int'(m_u); i >= 1; i--) begin
                mm[m_fp] = m_v[i];
                m_fp = m_fp + AW'(1);
            end
        end
        a = m_sp + k;
        mm[a] = DW'(m_fp);
        m_sp = a;
        m_fp = a;
        a = m_sp + AW'(1);
        mm[a] = DW'(m_u);
        m_sp = a;
        m_u = cnu;
        model_refill();
        call_pc = pc; op_arg = k; call_nu = nu; call_req = 1'b1;
        @(posedge clk); #1;
        call_req = 1'b0;
        chk("R2", "busy after call accept", 64'(busy), 64'd1);
        wait_done(disturb, cyc);
        chk("R10", "call cycles", 64'(cyc), 64'(exp_cyc));
        check_all(tag);
        depth++;
    endtask

    task automatic do_ret(input logic [AW-1:0] arg, input bit frame, input string tag);
        int exp_cyc, cyc;
        logic [AW-1:0] a;
        if (!frame) begin
            m_u = clampw(mm[m_sp]);
            m_rpc = m_tos[AW-1:0];
            a = m_fp - arg;
            m_tos = mm[a];
            m_sp = a - AW'(1);
            exp_cyc = 3;
        end else begin
            m_rpc = mm[m_fp + AW'(2)][AW-1:0];
            m_u = clampw(mm[m_fp + AW'(1)]);
            m_sp = m_fp - arg;
            exp_cyc = 4;
        end
        m_fp = mm[m_fp][AW-1:0];
        exp_cyc += (m_u != 0) ? 1 + int'(m_u) : 0;
        model_refill();
        op_arg = arg; ret_from_frame = frame; ret_req = 1'b1;
        @(posedge clk); #1;
        ret_req = 1'b0;
        chk("R2", "busy after return accept", 64'(busy), 64'd1);
        wait_done(1'b0, cyc);
        chk("R10", "return cycles", 64'(cyc), 64'(exp_cyc));
        check_all(tag);
        if (depth > 0) depth--;
    endtask

    task automatic write_local(input logic [1:0] sel, input logic [DW-1:0] val);
        loc_we = 1'b1; loc_sel = sel; loc_wdata = val;
        @(posedge clk); #1;
        loc_we = 1'b0;
        m_v[int'(sel) + 1] = val;
    endtask

    task automatic write_tos(input logic [DW-1:0] val);
        tos_we = 1'b1; tos_wdata = val;
        @(posedge clk); #1;
        tos_we = 1'b0;
        m_tos = val;
    endtask

    task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] val);
        mem[a] = val;
        mm[a] = val;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk("R2", "watchdog expired", 64'd1, 64'd0);
        summary();
        $finish;
    end

    initial begin : main
        int unsigned seed;
        logic [AW-1:0] fp_before;
        logic [AW-1:0] sp_before;
        logic [DW-1:0] tos_before;
        seed = $urandom(32'd20240611);
        for (int a = 0; a < 256; a++) begin
            mem[a] = DW'(a * 7 + 3);
            mm[a]  = DW'(a * 7 + 3);
        end
        m_fp = FP0; m_sp = SP0; m_u = '0; m_tos = '0; m_rpc = '0;
        for (int i = 1; i <= 4; i++) m_v[i] = '0;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "mem access", 64'({mem_we, mem_re}), 64'd0);
        check_all("R1");

        // R11: local and tos writes in idle
        write_local(2'd0, 16'h1111);
        write_local(2'd1, 16'h2222);
        write_local(2'd2, 16'h3333);
        write_local(2'd3, 16'h4444);
        write_tos(16'h0ABC);
        check_all("R11");

        // call with zero live count: spill skipped (R4), new count 4 refills (R6)
        sp_before = m_sp; tos_before = m_tos; fp_before = m_fp;
        do_call(8'h10, 8'd3, 3'd4, 1'b0, "R3/R4/R5/R6");
        chk("R3", "pushed tos word", 64'(mem[sp_before + AW'(1)]), 64'(tos_before));
        chk("R3", "tos holds pc+1", 64'(tos_val), 64'h11);
        chk("R5", "saved fp at new fp", 64'(mem[frame_ptr]), 64'(fp_before));
        chk("R5", "saved count above it", 64'(mem[frame_ptr + AW'(1)]), 64'd0);

        // full spill of four locals, clamp of field 7, requests while busy ignored
        write_local(2'd0, 16'hA001);
        write_local(2'd1, 16'hA002);
        write_local(2'd2, 16'hA003);
        write_local(2'd3, 16'hA004);
        fp_before = m_fp;
        do_call(8'h20, 8'd2, 3'd7, 1'b1, "R2/R11");
        chk("R4", "spill slot of v4", 64'(mem[fp_before - AW'(4)]), 64'hA004);
        chk("R4", "spill slot of v1", 64'(mem[fp_before - AW'(1)]), 64'hA001);
        chk("R7", "count clamped from field", 64'(live_cnt), 64'd4);

        // normal return restores the four spilled locals
        do_ret(8'd1, 1'b0, "R8/R6");
        chk("R6", "v4 refilled", 64'(locals[3*DW +: DW]), 64'hA004);
        chk("R8", "ret_pc from tos", 64'(ret_pc), 64'h21);

        // frame-held return with an out-of-range stored count
        poke(m_fp + AW'(1), 16'h0009);
        poke(m_fp + AW'(2), 16'h0033);
        do_ret(8'd2, 1'b1, "R9/R7");
        chk("R9", "ret_pc from frame", 64'(ret_pc), 64'h33);
        chk("R7", "count clamped from memory", 64'(live_cnt), 64'd4);
        depth = 0;

        // seeded random nesting
        for (int it = 0; it < 80; it++) begin
            int choice;
            choice = int'($urandom_range(0, 2));
            if (choice == 2)
                write_local(2'($urandom_range(0, 3)), 16'($urandom_range(0, 65535)));
            if (depth == 0 || (choice != 0 && depth < 6))
                do_call(8'($urandom_range(0, 255)), 8'($urandom_range(0, 6)),
                        3'($urandom_range(0, 7)), 1'b0, "R3/R4/R5/R6");
            else
                do_ret(8'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R8/R9/R6");
        end

        summary();
        $finish;
    end

endmodule